// File: doc/BRIEF.md
# SIMD Halving Add/Subtract Unit

This block performs a lane-parallel halving add or halving subtract on two packed integer vectors. Each operand is split into lanes of 8, 16 or 32 bits. For every lane, the matching elements are summed, or the second is subtracted from the first, at one bit more than the lane width so no carry or borrow is lost. That intermediate value is shifted right by one bit, and the low lane-width bits become the lane result. No rounding increment is applied.

Four run-time controls shape each operation: lane width, signed or unsigned interpretation, add or subtract, and a 64-bit or 128-bit vector length. A start strobe samples the operands and controls. The result is registered and appears with a one-cycle valid pulse on the next clock. The block produces no condition flags and no saturation status. An unsupported lane-size code raises an illegal flag and gives an all-zero result.

Top module: `simd_halve_unit`

## Requirements
- R1: With unsigned lanes (`is_unsigned`=1) and add (`subtract`=0), each lane result is the low lane-width bits of (a+b)>>1, with the carry out of the lane kept. For example, 8-bit lanes 0xFF and 0xFF give 0xFF.
- R2: With signed lanes (`is_unsigned`=0), elements are two's complement and the shift is arithmetic, so results round toward minus infinity. For example, -3 + 0 in an 8-bit lane gives 0xFE (-2).
- R3: With `subtract`=1, each lane result is the low lane-width bits of (a-b)>>1, formed at full precision. For example, unsigned 8-bit 0 - 1 gives 0xFF.
- R4: `lane_sel` encodes the lane width as follows: 2'b00 selects 8-bit lanes, 2'b01 selects 16-bit lanes and 2'b10 selects 32-bit lanes. Lane i occupies bits [i*W +: W].
- R5: `lane_sel`=2'b11 makes `illegal` 1 and `result` all zero when `result_valid` rises. A legal size gives `illegal`=0.
- R6: With `wide`=0, only bits [63:0] of the operands are used, and `result[127:64]` is zero. With `wide`=1, all 128 bits take part.
- R7: No carry or borrow crosses a lane boundary at any lane width.
- R8: `result`, `illegal` and `result_valid`=1 appear on the first rising edge after the one that samples `start`=1. `result_valid` is 0 after any edge that samples `start`=0.
- R9: Reset clears `result`, `illegal` and `result_valid` to zero.
- R10: `result` and `illegal` hold their values while `start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Samples operands and controls |
| is_unsigned | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| subtract | input | 1 | 1 = halving subtract, 0 = halving add |
| wide | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| lane_sel | input | 2 | Lane width code (00=8, 01=16, 10=32, 11=illegal) |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector |
| result | output | 128 | Registered lane results |
| result_valid | output | 1 | One-cycle pulse marking a new result |
| illegal | output | 1 | Registered flag for the unsupported size code |

## Verification
Every result, its illegal flag and its valid pulse are due one clock edge after the edge that samples the start strobe. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, so each check falls within that single registered stage. After an operation it leaves one idle cycle. It then confirms that the valid flag has dropped and that the result and flag did not move. Expected values come from a bench function that works each lane out with signed 64-bit integer arithmetic.

// File: rtl/simd_halve_unit.sv
module simd_halve_unit #(
  parameter int VEC_W  = 128,
  parameter int NSIZES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_unsigned,
  input  logic             subtract,
  input  logic             wide,
  input  logic [1:0]       lane_sel,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic [VEC_W-1:0] result,
  output logic             result_valid,
  output logic             illegal
);
  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] a_eff, b_eff, sel_res, next_res;
  logic [VEC_W-1:0] lanes [NSIZES];
  logic             bad_size;

  assign a_eff    = wide ? src_a : {{HALF_W{1'b0}}, src_a[HALF_W-1:0]};
  assign b_eff    = wide ? src_b : {{HALF_W{1'b0}}, src_b[HALF_W-1:0]};
  assign bad_size = (lane_sel == 2'b11);

  for (genvar k = 0; k < NSIZES; k++) begin : g_width
    localparam int W = 8 << k;
    for (genvar g = 0; g < VEC_W / W; g++) begin : g_lane
      logic [W-1:0] ea, eb;
      logic [W:0]   xa, xb, s;
      assign ea = a_eff[g*W +: W];
      assign eb = b_eff[g*W +: W];
      assign xa = {~is_unsigned & ea[W-1], ea};
      assign xb = {~is_unsigned & eb[W-1], eb};
      assign s  = subtract ? (xa - xb) : (xa + xb);
      assign lanes[k][g*W +: W] = s[W:1];
    end
  end

  always_comb begin
    sel_res = '0;
    for (int k = 0; k < NSIZES; k++)
      if (lane_sel == k[1:0]) sel_res = lanes[k];
  end

  assign next_res = bad_size ? '0 :
                    (wide ? sel_res : {{HALF_W{1'b0}}, sel_res[HALF_W-1:0]});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
      illegal      <= 1'b0;
    end else begin
      result_valid <= start;
      if (start) begin
        result  <= next_res;
        illegal <= bad_size;
      end
    end
  end

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && illegal |-> result == '0); // R5
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> illegal == $past(lane_sel == 2'b11)); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start && !wide |=> result[VEC_W-1:HALF_W] == '0); // R6
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> result_valid); // R8
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !result_valid); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result) && $stable(illegal)); // R10
endmodule

// File: tb/simd_halve_unit_tb.sv
module simd_halve_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         is_unsigned = 1'b0;
  logic         subtract = 1'b0;
  logic         wide = 1'b0;
  logic [1:0]   lane_sel = 2'b00;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic [127:0] result;
  logic         result_valid;
  logic         illegal;
  int           n_run = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  simd_halve_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .is_unsigned(is_unsigned),
    .subtract(subtract), .wide(wide), .lane_sel(lane_sel),
    .src_a(src_a), .src_b(src_b), .result(result),
    .result_valid(result_valid), .illegal(illegal)
  );

  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b,
                                         bit u, bit sub, bit q, logic [1:0] sz);
    logic [127:0] r = '0;
    if (sz == 2'b11) return r;
    begin
      int w = 8 << sz;
      int n = (q ? 128 : 64) / w;
      longint mask = (longint'(1) << w) - 1;
      for (int e = 0; e < n; e++) begin
        longint x = longint'((a >> (e * w)) & 128'(mask));
        longint y = longint'((b >> (e * w)) & 128'(mask));
        longint s;
        if (!u && x[w-1]) x = x - (longint'(1) << w);
        if (!u && y[w-1]) y = y - (longint'(1) << w);
        s = sub ? x - y : x + y;
        s = s >>> 1;
        r = r | ((128'(s) & 128'(mask)) << (e * w));
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [127:0] a, logic [127:0] b,
                        bit u, bit sub, bit q, logic [1:0] sz);
    logic [127:0] exp = model(a, b, u, sub, q, sz);
    logic [127:0] held;
    logic         held_ill;
    src_a = a; src_b = b; is_unsigned = u; subtract = sub;
    wide = q; lane_sel = sz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " R8 valid"}, 128'(result_valid), 128'(1));
    check(req, result, exp);
    check({req, " R5 flag"}, 128'(illegal), 128'(sz == 2'b11));
    held = result; held_ill = illegal;
    src_a = ~a; src_b = a ^ b; subtract = ~sub; lane_sel = ~sz;
    @(negedge clk);
    check("R8 valid drop", 128'(result_valid), 128'(0));
    check("R10 hold", result, held);
    check("R10 hold flag", 128'(illegal), 128'(held_ill));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [127:0] ra, rb;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R9 result", result, '0);
    check("R9 valid", 128'(result_valid), 128'(0));
    check("R9 illegal", 128'(illegal), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R1 R7 unsigned carry", {16{8'hFF}}, {16{8'hFF}}, 1, 0, 1, 2'b00);
    check("R1 lanes 0xFF", result, {16{8'hFF}});
    run_op("R2 signed -3", {16{8'hFD}}, '0, 0, 0, 1, 2'b00);
    check("R2 lanes 0xFE", result, {16{8'hFE}});
    run_op("R3 sub borrow", '0, {16{8'h01}}, 1, 1, 1, 2'b00);
    check("R3 lanes 0xFF", result, {16{8'hFF}});
    run_op("R4 R7 16-bit", {8{16'hFFFF}}, {8{16'h0001}}, 1, 0, 1, 2'b01);
    run_op("R4 R7 32-bit", {4{32'h8000_0000}}, {4{32'h8000_0000}}, 0, 0, 1, 2'b10);
    run_op("R5 illegal size", {4{32'h1234_5678}}, {4{32'h9ABC_DEF0}}, 1, 0, 1, 2'b11);
    run_op("R6 narrow", {{64{1'b1}}, {8{8'h10}}}, {{64{1'b1}}, {8{8'h20}}}, 1, 0, 0, 2'b00);
    check("R6 upper zero", {64'(result[127:64]), 64'd0}, '0);

    for (int i = 0; i < 400; i++) begin
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      if (i % 5 == 0) rb = ~ra;
      run_op("R1 R2 R3 R4 R6 R7 random", ra, rb, 1'($urandom), 1'($urandom),
             1'($urandom), 2'($urandom));
    end

    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset result", result, '0);
    check("R9 reset valid", 128'(result_valid), 128'(0));
    finish_up();
  end
endmodule